// File: doc/BRIEF.md
# Hashed Page Entry Search Engine

This block resolves a translation miss by searching a hashed page table held in memory. A request carries the virtual segment identifier, the abbreviated page index, a load/store flag and the addresses of two entry groups (primary and secondary). The hash that produces those group addresses is computed elsewhere. The engine walks the primary group and then, if nothing matched, the secondary group. It fetches one 64-bit entry per memory transaction and stops at the first entry that matches.

On a match the engine returns the real page number, the four storage-attribute bits and the two protection bits. It also reports which group supplied the entry. If the entry's history bits need updating, it writes the entry back first. If both groups are exhausted without a match, it reports a page fault. The engine handles one request at a time and signals completion with a one-cycle pulse. The result outputs hold their values until the next request is accepted.

Top module: `pte_walker`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `done` and `mem_req_valid` are 0.
- R2: An entry matches only if all of these hold:
  - bit 63 (valid) is 1;
  - bits 62:39 equal the request's 24-bit segment identifier;
  - bits 37:32 equal the request's 6-bit page index.
  
  An entry whose valid bit is 0 is skipped, even when its other fields match.
- R3: Bit 38 (hash flag) of a matching entry must be 0 in the primary group and 1 in the secondary group. An entry whose other fields match but whose hash flag is wrong for its group is skipped.
- R4: Reads are issued in a fixed order:
  - primary slots 0 to 7 at the primary base address plus 8 times the slot number;
  - then, only if the primary group had no match, the secondary slots in the same way.
  
  The search stops at the first matching entry. Group bases are 64-byte aligned, so every access address is 8-byte aligned.
- R5: If none of the 16 entries matches, `done` rises with `fault` = 1 and the translation outputs are zero.
- R6: On a match, `done` rises with `fault` = 0. The outputs carry:
  - `res_rpn` from entry bits 31:12;
  - `res_wimg` from bits 6:3;
  - `res_pp` from bits 1:0;
  - `hit_secondary` = 1 if the entry came from the secondary group.
- R7: On a match, a single write to the matching entry's address is issued before `done`. The write sets bit 8 (referenced) and, for a store request, bit 7 (changed), and leaves all other bits unchanged. The write is omitted when those bits are already set.
- R8: `busy` is 1 from the cycle after a request is accepted through the cycle in which `done` pulses. A request presented while `busy` is 1 is ignored.
- R9: At most one memory transaction is outstanding. No new request is issued before the response to the previous one.
- R10: `done` is high for exactly one cycle per search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a search (taken when not busy) |
| req_store | input | 1 | 1 = store access, 0 = load |
| req_vsid | input | 24 | Segment identifier to match |
| req_api | input | 6 | Abbreviated page index to match |
| req_pteg_pri | input | ADDR_W | Primary group base address |
| req_pteg_sec | input | ADDR_W | Secondary group base address |
| busy | output | 1 | Search in progress |
| mem_req_valid | output | 1 | Memory request, one cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address of the entry |
| mem_req_wdata | output | 64 | Write data |
| mem_resp_valid | input | 1 | Memory response (read data or write acknowledge) |
| mem_resp_rdata | input | 64 | Read data |
| done | output | 1 | Completion pulse |
| fault | output | 1 | No matching entry found |
| hit_secondary | output | 1 | Match came from the secondary group |
| res_rpn | output | 20 | Real page number |
| res_wimg | output | 4 | Storage attribute bits |
| res_pp | output | 2 | Protection bits |

## Verification
The bench fills group memory with several kinds of entries:
- entries that fail on only one field (valid bit, segment identifier, page index or hash flag), which show that each field takes part in the compare;
- two matching entries in one group, which shows that the lowest slot wins;
- groups with a correct secondary match, and groups with no match at all, which separate the secondary walk from the fault path.

Repeating a search after the first one has set the history bits, and running loads and stores against entries whose referenced bit is already set, separates the write-back from the skipped write-back. A request injected in the middle of a long search shows whether the engine ignores input while busy. The read sequence is compared address by address against a behavioural walk under a varying response latency.

// File: rtl/pte_walk_pkg.sv
// Package: shared constants and types for the page entry search engine.
// Entry bit positions are little-endian indices within the 64-bit entry
// (upper word = bits 63:32).
package pte_walk_pkg;

    localparam int ENTRY_W   = 64;
    localparam int VSID_W    = 24;
    localparam int API_W     = 6;
    localparam int RPN_W     = 20;
    localparam int WIMG_W    = 4;
    localparam int PP_W      = 2;
    localparam int OFF_SHIFT = 3;   // log2 of the entry size in bytes

    localparam int V_BIT     = 63;
    localparam int VSID_LSB  = 39;
    localparam int H_BIT     = 38;
    localparam int API_LSB   = 32;
    localparam int RPN_LSB   = 12;
    localparam int R_BIT     = 8;
    localparam int C_BIT     = 7;
    localparam int WIMG_LSB  = 3;
    localparam int PP_LSB    = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RD_WAIT,
        ST_WR,
        ST_WR_WAIT,
        ST_DONE
    } walk_state_t;

    typedef struct packed {
        logic [RPN_W-1:0]  rpn;
        logic [WIMG_W-1:0] wimg;
        logic [PP_W-1:0]   pp;
    } xlate_t;

endpackage

// File: rtl/pte_entry_match.sv
// Module: pte_entry_match
// Combinational compare of one fetched entry against the search key.
// Also forms the history-bit write-back image.
// Assumes: pass = 0 for the primary group, 1 for the secondary group.
module pte_entry_match
    import pte_walk_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic [VSID_W-1:0]  vsid,
    input  logic [API_W-1:0]   api,
    input  logic               pass,
    input  logic               store,
    output logic               hit,
    output logic               wb_need,
    output logic [ENTRY_W-1:0] wb_data,
    output xlate_t             fields
);

    // Key compare: valid, segment id, hash flag for this pass, page index.
    always_comb begin
        hit = entry[V_BIT]
           && (entry[VSID_LSB +: VSID_W] == vsid)
           && (entry[H_BIT] == pass)
           && (entry[API_LSB +: API_W] == api);
    end

    // History bits: write only when something would change.
    always_comb begin
        wb_need = !entry[R_BIT] || (store && !entry[C_BIT]);
        wb_data = entry;
        wb_data[R_BIT] = 1'b1;
        if (store) begin
            wb_data[C_BIT] = 1'b1;
        end
    end

    // Translation fields taken from the lower word.
    always_comb begin
        fields.rpn  = entry[RPN_LSB  +: RPN_W];
        fields.wimg = entry[WIMG_LSB +: WIMG_W];
        fields.pp   = entry[PP_LSB   +: PP_W];
    end

endmodule

// File: rtl/pte_slot_seq.sv
// Module: pte_slot_seq
// Holds the two group bases and walks slot 0..SLOTS-1 of the primary group,
// then of the secondary group. Produces the current entry address.
// Assumes: bases are aligned to SLOTS entries; step is never asserted
// once exhausted is high.
module pte_slot_seq
    import pte_walk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SLOTS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_pri,
    input  logic [ADDR_W-1:0] base_sec,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              pass,
    output logic              exhausted
);

    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic [ADDR_W-1:0] pri_q;
    logic [ADDR_W-1:0] sec_q;
    logic [SLOT_W-1:0] slot_q;
    logic              pass_q;
    logic              last_slot;

    // Slot/pass counter: restart on load, advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_q  <= '0;
            sec_q  <= '0;
            slot_q <= '0;
            pass_q <= 1'b0;
        end else if (load) begin
            pri_q  <= base_pri;
            sec_q  <= base_sec;
            slot_q <= '0;
            pass_q <= 1'b0;
        end else if (step) begin
            if (last_slot) begin
                slot_q <= '0;
                pass_q <= 1'b1;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    // Address: selected base plus slot times the entry size.
    always_comb begin
        last_slot = (slot_q == LAST_SLOT);
        exhausted = pass_q && last_slot;
        pass      = pass_q;
        addr      = (pass_q ? sec_q : pri_q)
                  + ADDR_W'({slot_q, {OFF_SHIFT{1'b0}}});
    end

    // The controller must fault rather than step past the final slot.
    assert_no_step_past_end_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        step |-> !exhausted
    ) else $error("step issued after the last secondary slot");

endmodule

// File: rtl/pte_walk_ctrl.sv
// Module: pte_walk_ctrl
// Search state machine: accepts a request, issues one read per slot,
// evaluates each response, writes history bits back on a hit and
// reports completion.
// Assumes: the memory answers every request (read or write) with exactly
// one mem_resp_valid pulse, never unprompted.
module pte_walk_ctrl
    import pte_walk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_store,
    input  logic [VSID_W-1:0]  req_vsid,
    input  logic [API_W-1:0]   req_api,
    output logic [VSID_W-1:0]  key_vsid,
    output logic [API_W-1:0]   key_api,
    output logic               key_store,
    output logic               seq_load,
    output logic               seq_step,
    input  logic               seq_pass,
    input  logic               seq_exhausted,
    input  logic               m_hit,
    input  logic               m_wb_need,
    input  logic [ENTRY_W-1:0] m_wb_data,
    input  xlate_t             m_fields,
    output logic               mem_req_valid,
    output logic               mem_req_write,
    output logic [ENTRY_W-1:0] mem_req_wdata,
    input  logic               mem_resp_valid,
    output logic               busy,
    output logic               done,
    output logic               fault,
    output logic               hit_secondary,
    output xlate_t             result
);

    walk_state_t        state_q;
    logic [ENTRY_W-1:0] wdata_q;
    logic               fault_q;
    logic               sec_q;
    xlate_t             result_q;
    logic               outstanding_q;

    // Main sequencing and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            key_vsid  <= '0;
            key_api   <= '0;
            key_store <= 1'b0;
            wdata_q   <= '0;
            fault_q   <= 1'b0;
            sec_q     <= 1'b0;
            result_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        key_vsid  <= req_vsid;
                        key_api   <= req_api;
                        key_store <= req_store;
                        fault_q   <= 1'b0;
                        sec_q     <= 1'b0;
                        result_q  <= '0;
                        state_q   <= ST_RD;
                    end
                end
                ST_RD: state_q <= ST_RD_WAIT;
                ST_RD_WAIT: begin
                    if (mem_resp_valid) begin
                        if (m_hit) begin
                            sec_q    <= seq_pass;
                            result_q <= m_fields;
                            if (m_wb_need) begin
                                wdata_q <= m_wb_data;
                                state_q <= ST_WR;
                            end else begin
                                state_q <= ST_DONE;
                            end
                        end else if (seq_exhausted) begin
                            fault_q <= 1'b1;
                            state_q <= ST_DONE;
                        end else begin
                            state_q <= ST_RD;
                        end
                    end
                end
                ST_WR: state_q <= ST_WR_WAIT;
                ST_WR_WAIT: begin
                    if (mem_resp_valid) begin
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Tracks an issued memory request awaiting its response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding_q <= 1'b0;
        end else if (mem_req_valid) begin
            outstanding_q <= 1'b1;
        end else if (mem_resp_valid) begin
            outstanding_q <= 1'b0;
        end
    end

    // Decoded controls and outputs from the current state.
    always_comb begin
        seq_load      = (state_q == ST_IDLE) && req_valid;
        seq_step      = (state_q == ST_RD_WAIT) && mem_resp_valid
                     && !m_hit && !seq_exhausted;
        mem_req_valid = (state_q == ST_RD) || (state_q == ST_WR);
        mem_req_write = (state_q == ST_WR);
        mem_req_wdata = wdata_q;
        busy          = (state_q != ST_IDLE);
        done          = (state_q == ST_DONE);
        fault         = fault_q;
        hit_secondary = sec_q;
        result        = result_q;
    end

    assert_one_outstanding_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !outstanding_q
    ) else $error("new memory request while one is outstanding");

    assert_done_pulse_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        done |=> !done
    ) else $error("done held longer than one cycle");

    assert_busy_at_done_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        done |-> busy
    ) else $error("done without busy");

    assert_idle_quiet_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid
    ) else $error("memory request while idle");

    assert_wb_sets_ref_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> mem_req_wdata[R_BIT]
    ) else $error("write-back without referenced bit");

    assert_fault_blank_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (result == '0 && !hit_secondary)
    ) else $error("fault with nonzero translation");

endmodule

// File: rtl/pte_walker.sv
// Module: pte_walker (top)
// Two-group hashed page entry search engine with a single-outstanding
// 64-bit memory port.
// Assumes: group bases are 64-byte aligned and computed outside the block.
module pte_walker
    import pte_walk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SLOTS  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_store,
    input  logic [VSID_W-1:0]  req_vsid,
    input  logic [API_W-1:0]   req_api,
    input  logic [ADDR_W-1:0]  req_pteg_pri,
    input  logic [ADDR_W-1:0]  req_pteg_sec,
    output logic               busy,
    output logic               mem_req_valid,
    output logic               mem_req_write,
    output logic [ADDR_W-1:0]  mem_req_addr,
    output logic [ENTRY_W-1:0] mem_req_wdata,
    input  logic               mem_resp_valid,
    input  logic [ENTRY_W-1:0] mem_resp_rdata,
    output logic               done,
    output logic               fault,
    output logic               hit_secondary,
    output logic [RPN_W-1:0]   res_rpn,
    output logic [WIMG_W-1:0]  res_wimg,
    output logic [PP_W-1:0]    res_pp
);

    logic [VSID_W-1:0]  key_vsid;
    logic [API_W-1:0]   key_api;
    logic               key_store;
    logic               seq_load;
    logic               seq_step;
    logic               seq_pass;
    logic               seq_exhausted;
    logic               m_hit;
    logic               m_wb_need;
    logic [ENTRY_W-1:0] m_wb_data;
    xlate_t             m_fields;
    xlate_t             result;

    pte_slot_seq #(
        .ADDR_W (ADDR_W),
        .SLOTS  (SLOTS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (seq_load),
        .base_pri  (req_pteg_pri),
        .base_sec  (req_pteg_sec),
        .step      (seq_step),
        .addr      (mem_req_addr),
        .pass      (seq_pass),
        .exhausted (seq_exhausted)
    );

    pte_entry_match u_match (
        .entry   (mem_resp_rdata),
        .vsid    (key_vsid),
        .api     (key_api),
        .pass    (seq_pass),
        .store   (key_store),
        .hit     (m_hit),
        .wb_need (m_wb_need),
        .wb_data (m_wb_data),
        .fields  (m_fields)
    );

    pte_walk_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_store      (req_store),
        .req_vsid       (req_vsid),
        .req_api        (req_api),
        .key_vsid       (key_vsid),
        .key_api        (key_api),
        .key_store      (key_store),
        .seq_load       (seq_load),
        .seq_step       (seq_step),
        .seq_pass       (seq_pass),
        .seq_exhausted  (seq_exhausted),
        .m_hit          (m_hit),
        .m_wb_need      (m_wb_need),
        .m_wb_data      (m_wb_data),
        .m_fields       (m_fields),
        .mem_req_valid  (mem_req_valid),
        .mem_req_write  (mem_req_write),
        .mem_req_wdata  (mem_req_wdata),
        .mem_resp_valid (mem_resp_valid),
        .busy           (busy),
        .done           (done),
        .fault          (fault),
        .hit_secondary  (hit_secondary),
        .result         (result)
    );

    // Unpack the held translation result onto the ports.
    always_comb begin
        res_rpn  = result.rpn;
        res_wimg = result.wimg;
        res_pp   = result.pp;
    end

    assert_aligned_access_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[OFF_SHIFT-1:0] == '0)
    ) else $error("unaligned entry access");

endmodule

// File: tb/sim_pte_walker.sv
// Bench for pte_walker: a behavioural memory with varying latency and a
// behavioural walk model. Every memory request is compared against the
// model's expected sequence, and busy is checked on every clock.
module sim_pte_walker;

    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_store = 1'b0;
    logic [23:0]       req_vsid = '0;
    logic [5:0]        req_api = '0;
    logic [ADDR_W-1:0] req_pteg_pri = '0;
    logic [ADDR_W-1:0] req_pteg_sec = '0;
    logic              busy;
    logic              mem_req_valid;
    logic              mem_req_write;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [63:0]       mem_req_wdata;
    logic              mem_resp_valid = 1'b0;
    logic [63:0]       mem_resp_rdata = '0;
    logic              done;
    logic              fault;
    logic              hit_secondary;
    logic [19:0]       res_rpn;
    logic [3:0]        res_wimg;
    logic [1:0]        res_pp;

    always #10 clk = ~clk;   // 50 MHz

    pte_walker #(.ADDR_W(ADDR_W), .SLOTS(8)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_vsid(req_vsid), .req_api(req_api), .req_pteg_pri(req_pteg_pri),
        .req_pteg_sec(req_pteg_sec), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_resp_valid(mem_resp_valid),
        .mem_resp_rdata(mem_resp_rdata), .done(done), .fault(fault),
        .hit_secondary(hit_secondary), .res_rpn(res_rpn), .res_wimg(res_wimg),
        .res_pp(res_pp)
    );

    int tests_run = 0;
    int tests_failed = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural memory ----------------
    logic [63:0] mem [logic [31:0]];
    int          lat_seed = 0;
    int          resp_cnt = 0;
    logic [31:0] resp_addr = '0;
    logic        resp_wr = 1'b0;

    function automatic logic [63:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'h0;
    endfunction

    // Entry image: V, VSID, H, API | RPN, 000, R, C, WIMG, 0, PP
    function automatic logic [63:0] mk(input bit v, input logic [23:0] vsid,
                                       input bit h, input logic [5:0] api,
                                       input logic [19:0] rpn, input bit r,
                                       input bit c, input logic [3:0] wimg,
                                       input logic [1:0] pp);
        return {v, vsid, h, api, rpn, 3'b000, r, c, wimg, 1'b0, pp};
    endfunction

    // Responder: one response per request after 1..3 cycles.
    always @(negedge clk) begin
        mem_resp_valid = 1'b0;
        if (resp_cnt != 0) begin
            resp_cnt--;
            if (resp_cnt == 0) begin
                mem_resp_valid = 1'b1;
                mem_resp_rdata = resp_wr ? 64'h0 : rd(resp_addr);
            end
        end
        if (mem_req_valid) begin
            resp_addr = mem_req_addr;
            resp_wr   = mem_req_write;
            if (mem_req_write) mem[mem_req_addr] = mem_req_wdata;
            resp_cnt  = 1 + (lat_seed % 3);
            lat_seed++;
        end
    end

    // ---------------- reference walk ----------------
    logic [31:0] exp_addr [$];
    bit          exp_wr   [$];
    logic [63:0] exp_data [$];
    bit          e_fault;
    bit          e_sec;
    logic [19:0] e_rpn;
    logic [3:0]  e_wimg;
    logic [1:0]  e_pp;

    task automatic model(input logic [23:0] vsid, input logic [5:0] api,
                         input bit store, input logic [31:0] pri,
                         input logic [31:0] sec);
        logic [63:0] e;
        logic [63:0] w;
        logic [31:0] a;
        exp_addr.delete(); exp_wr.delete(); exp_data.delete();
        e_fault = 1'b1; e_sec = 1'b0; e_rpn = '0; e_wimg = '0; e_pp = '0;
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 8; s++) begin
                a = ((p == 0) ? pri : sec) + 32'(s * 8);
                e = rd(a);
                exp_addr.push_back(a); exp_wr.push_back(1'b0); exp_data.push_back('0);
                if (e[63] && e[62:39] == vsid && e[37:32] == api && e[38] == p[0]) begin
                    e_fault = 1'b0; e_sec = p[0];
                    e_rpn = e[31:12]; e_wimg = e[6:3]; e_pp = e[1:0];
                    w = e; w[8] = 1'b1; if (store) w[7] = 1'b1;
                    if (w != e) begin
                        exp_addr.push_back(a); exp_wr.push_back(1'b1); exp_data.push_back(w);
                    end
                    return;
                end
            end
        end
    endtask

    // Every memory request is compared with the head of the expected list.
    always @(negedge clk) begin
        if (rst_n && mem_req_valid) begin
            if (exp_addr.size() == 0) begin
                chk(1'b0, "R4", "unexpected request addr", {32'h0, mem_req_addr}, 64'h0);
            end else begin
                logic [31:0] ea;
                bit          ew;
                logic [63:0] ed;
                ea = exp_addr.pop_front();
                ew = exp_wr.pop_front();
                ed = exp_data.pop_front();
                chk(mem_req_addr == ea, "R4", "request address", {32'h0, mem_req_addr}, {32'h0, ea});
                chk(mem_req_write == ew, "R7", "request kind", {63'h0, mem_req_write}, {63'h0, ew});
                if (ew && mem_req_write)
                    chk(mem_req_wdata == ed, "R7", "write-back data", mem_req_wdata, ed);
            end
        end
    end

    // One search: drive, track busy every clock, check the result at done.
    task automatic search(input string tag, input logic [23:0] vsid,
                          input logic [5:0] api, input bit store,
                          input logic [31:0] pri, input logic [31:0] sec,
                          input bit poke);
        int cyc;
        model(vsid, api, store, pri, sec);
        @(negedge clk);
        req_valid = 1'b1; req_store = store; req_vsid = vsid; req_api = api;
        req_pteg_pri = pri; req_pteg_sec = sec;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 2000) begin
            chk(busy == 1'b1, "R8", {tag, " busy during search"}, {63'h0, busy}, 64'h1);
            if (poke && cyc == 4) begin
                // R8: a request while busy must not disturb the walk
                req_valid = 1'b1; req_vsid = ~vsid; req_pteg_pri = pri + 32'h1000;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        chk(done == 1'b1, "R8", {tag, " completion"}, {63'h0, done}, 64'h1);
        chk(fault == e_fault, "R5", {tag, " fault"}, {63'h0, fault}, {63'h0, e_fault});
        chk(hit_secondary == e_sec, "R6", {tag, " group"}, {63'h0, hit_secondary}, {63'h0, e_sec});
        chk(res_rpn == e_rpn, "R6", {tag, " rpn"}, {44'h0, res_rpn}, {44'h0, e_rpn});
        chk(res_wimg == e_wimg, "R6", {tag, " wimg"}, {60'h0, res_wimg}, {60'h0, e_wimg});
        chk(res_pp == e_pp, "R6", {tag, " pp"}, {62'h0, res_pp}, {62'h0, e_pp});
        chk(exp_addr.size() == 0, "R4", {tag, " all expected requests issued"},
            64'(exp_addr.size()), 64'h0);
        @(negedge clk);
        chk(done == 1'b0, "R10", {tag, " done pulse length"}, {63'h0, done}, 64'h0);
        chk(busy == 1'b0, "R8", {tag, " busy clears"}, {63'h0, busy}, 64'h0);
    endtask

    function automatic logic [31:0] grp(input int k);
        return 32'h0002_0000 + 32'(k * 64);
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #3_000_000;
        tests_failed++;
        $display("FAIL R8 watchdog expired: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && mem_req_valid == 1'b0, "R1", "outputs in reset",
            {61'h0, busy, done, mem_req_valid}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && mem_req_valid == 1'b0, "R1", "outputs after reset",
            {61'h0, busy, done, mem_req_valid}, 64'h0);

        // R6/R7: primary slot 0, load, sets referenced only
        mem[grp(0)] = mk(1, 24'h1A2B3C, 0, 6'h05, 20'h12345, 0, 0, 4'hA, 2'd2);
        search("t1", 24'h1A2B3C, 6'h05, 0, grp(0), grp(1), 0);

        // R2: invalid / wrong-vsid / wrong-api entries skipped; store sets R and C
        mem[grp(2) + 0]  = mk(0, 24'h00BEEF, 0, 6'h11, 20'h11111, 0, 0, 4'h1, 2'd1);
        mem[grp(2) + 8]  = mk(1, 24'h00BEEE, 0, 6'h11, 20'h22222, 0, 0, 4'h2, 2'd1);
        mem[grp(2) + 16] = mk(1, 24'h00BEEF, 0, 6'h10, 20'h33333, 0, 0, 4'h3, 2'd1);
        mem[grp(2) + 24] = mk(1, 24'h00BEEF, 0, 6'h11, 20'hABCDE, 0, 0, 4'h5, 2'd1);
        mem[grp(2) + 40] = mk(1, 24'h00BEEF, 0, 6'h11, 20'h55555, 0, 0, 4'h6, 2'd0);
        search("t2", 24'h00BEEF, 6'h11, 1, grp(2), grp(3), 0);

        // R7: repeat store, bits already set, no write-back
        search("t3", 24'h00BEEF, 6'h11, 1, grp(2), grp(3), 0);

        // R7: R set, C clear: load skips the write, store writes C
        mem[grp(4) + 56] = mk(1, 24'h777777, 0, 6'h3F, 20'h0F0F0, 1, 0, 4'h9, 2'd3);
        search("t4", 24'h777777, 6'h3F, 0, grp(4), grp(5), 0);
        search("t5", 24'h777777, 6'h3F, 1, grp(4), grp(5), 0);

        // R3: primary entry with H=1 skipped; secondary entry with H=1 hits
        mem[grp(6) + 16] = mk(1, 24'h424242, 1, 6'h2A, 20'h99999, 0, 0, 4'h4, 2'd2);
        mem[grp(8) + 32] = mk(1, 24'h424242, 1, 6'h2A, 20'h13579, 0, 0, 4'hC, 2'd1);
        search("t6", 24'h424242, 6'h2A, 0, grp(6), grp(8), 0);

        // R3/R5/R8: wrong H in both groups gives a fault; request while busy ignored
        mem[grp(10) + 8]  = mk(1, 24'h0000AA, 1, 6'h01, 20'h44444, 0, 0, 4'h7, 2'd2);
        mem[grp(12) + 48] = mk(1, 24'h0000AA, 0, 6'h01, 20'h66666, 0, 0, 4'h8, 2'd2);
        search("t7", 24'h0000AA, 6'h01, 1, grp(10), grp(12), 1);

        // R4: two matches in the primary group, lower slot wins
        mem[grp(14) + 16] = mk(1, 24'h5A5A5A, 0, 6'h22, 20'h2468A, 0, 0, 4'h2, 2'd0);
        mem[grp(14) + 32] = mk(1, 24'h5A5A5A, 0, 6'h22, 20'hFEDCB, 0, 0, 4'hE, 2'd3);
        search("t8", 24'h5A5A5A, 6'h22, 0, grp(14), grp(15), 0);

        // R6: all-ones fields, history already set
        mem[grp(16) + 48] = mk(1, 24'hFFFFFF, 0, 6'h3F, 20'hFFFFF, 1, 1, 4'hF, 2'd3);
        search("t9", 24'hFFFFFF, 6'h3F, 0, grp(16), grp(17), 0);

        // R5: both groups empty
        search("t10", 24'h123456, 6'h00, 0, grp(20), grp(22), 0);

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule